// File: doc/BRIEF.md
# Transmit-Ready Threshold and Idle Monitor

This block sits beside the outgoing byte buffer of one host port. It watches the buffer fill level and raises a transmit-ready pin towards the host once enough bytes are waiting. The pin then stays active until every pending byte has been handed to the port's transmit hardware. At that point up to 16 bytes may still be in flight in that hardware stage. The active level of the pin is programmable, and the whole pin function can be switched off. After reset it is off.

The block also supervises the host. When the host has not touched the port for a programmable interval (about two seconds by default), the port is declared idle and the packet scheduler must stop queueing new packets for it. In extended-timeout mode the idle declaration also waits until the backlog of undelivered bytes reaches 4 KiB. Any host access wakes the port and restarts the interval. The interval is built from a millisecond prescaler driven by a clock-frequency parameter, so a bench can shorten it.

A configuration write loads the enable, polarity, threshold and timeout mode together. A threshold that is out of range is never stored. In that case the ready-pin settings are cleared to all zero while the timeout mode is still taken.

Top module: `txrdy_idle_mon`

## Requirements
- R1: After reset the pin function is disabled, `tx_ready` is 0 and `port_idle` is 0.
- R2: With `cfg_active_low`=1 the pin is 1 when inactive and 0 when active. With `cfg_active_low`=0 it is 0 when inactive and 1 when active.
- R3: While enabled, the pin goes active on the clock after a cycle in which `buf_level` is nonzero and at least the stored threshold.
- R4: Once active, the pin stays active while `buf_level` is nonzero, even below the threshold. It goes inactive on the clock after `buf_level` is 0.
- R5: While inactive, a nonzero `buf_level` below the threshold leaves the pin inactive.
- R6: With extended timeout off, `port_idle` rises on the clock after `IDLE_MS` milliseconds (`IDLE_MS*CLK_HZ/1000` clocks) without `host_access`.
- R7: With extended timeout on, an expired interval sets `port_idle` only once `buf_level` is at least 4096.
- R8: `host_access` clears `port_idle` on the next clock and restarts the inactivity interval from zero.
- R9: A write with `cfg_enable`=1 and a threshold of 0 or above 2048 stores enable=0, polarity=0 and threshold=0. `cfg_ext_timeout` from the same write is still stored.
- R10: A configuration write takes effect on the clock that samples `cfg_wr`. A threshold of exactly 2048 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Load the configuration fields below |
| cfg_enable | input | 1 | Enable the ready pin |
| cfg_active_low | input | 1 | 1: pin active low, 0: active high |
| cfg_ext_timeout | input | 1 | Extended-timeout mode |
| cfg_threshold | input | LVL_W | Pending-byte count that arms the pin |
| host_access | input | 1 | Pulse for each host access to the port |
| buf_level | input | LVL_W | Bytes in the buffer not yet handed to the transmit hardware |
| tx_ready | output | 1 | Transmit-ready pin |
| port_idle | output | 1 | Port declared idle; refuse new packets |

## Verification
The hardest state to reach is an idle declaration in extended mode. It needs a full silent interval and a backlog of at least 4096 bytes at the same time. It also needs extended mode itself, and here that mode is loaded through a rejected configuration write. The bench shortens the interval to 100 clocks through the clock-frequency parameter. It then makes a write with an illegal threshold that still carries the mode bit, and holds the backlog at 100, 4095 and 4096 across the expiry. This shows that the rejected write kept the mode and that the backlog boundary is exact.

// File: rtl/txr_pkg.sv
package txr_pkg;

   typedef struct packed {
      logic en;
      logic act_low;
      logic ext;
   } txr_flags_t;

   typedef enum logic {
      PORT_LIVE = 1'b0,
      PORT_IDLE = 1'b1
   } txr_port_e;

endpackage

// File: rtl/txr_cfg_reg.sv
module txr_cfg_reg
   import txr_pkg::*;
#(
   parameter int LVL_W   = 13,
   parameter int THR_MAX = 2048
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             en_in,
   input  logic             act_low_in,
   input  logic             ext_in,
   input  logic [LVL_W-1:0] thr_in,
   output txr_flags_t       flags_q,
   output logic [LVL_W-1:0] thr_q
);

   localparam logic [LVL_W-1:0] THR_LIMIT = LVL_W'(THR_MAX);

   logic bad_thr;

   assign bad_thr = en_in && ((thr_in == '0) || (thr_in > THR_LIMIT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         thr_q   <= '0;
      end else if (wr) begin
         flags_q.ext <= ext_in;
         if (bad_thr) begin
            flags_q.en      <= 1'b0;
            flags_q.act_low <= 1'b0;
            thr_q           <= '0;
         end else begin
            flags_q.en      <= en_in;
            flags_q.act_low <= act_low_in;
            thr_q           <= thr_in;
         end
      end
   end

endmodule

// File: rtl/txr_ready_ctrl.sv
module txr_ready_ctrl #(
   parameter int LVL_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [LVL_W-1:0] thr,
   input  logic [LVL_W-1:0] level,
   output logic             armed
);

   logic has_data;
   logic over_thr;
   logic armed_d;

   assign has_data = (level != '0);
   assign over_thr = (level >= thr);
   assign armed_d  = en && has_data && (armed || over_thr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= armed_d;
   end

endmodule

// File: rtl/txr_idle_timer.sv
module txr_idle_timer
   import txr_pkg::*;
#(
   parameter int CLK_HZ  = 100_000_000,
   parameter int IDLE_MS = 2000,
   parameter int LVL_W   = 13,
   parameter int BACKLOG = 4096
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             access,
   input  logic             ext,
   input  logic [LVL_W-1:0] level,
   output txr_port_e        state_q
);

   localparam int PRE  = CLK_HZ / 1000;
   localparam int PRE_W = (PRE > 1) ? $clog2(PRE) : 1;
   localparam int MS_W = $clog2(IDLE_MS + 1);
   localparam logic [MS_W-1:0]  MS_END   = MS_W'(IDLE_MS);
   localparam logic [LVL_W-1:0] BL_LIMIT = LVL_W'(BACKLOG);

   logic            ms_tick;
   logic [MS_W-1:0] ms_q;
   logic            expired;
   logic            backlog_ok;

   generate
      if (PRE == 1) begin : g_direct
         assign ms_tick = 1'b1;
      end else begin : g_presc
         localparam logic [PRE_W-1:0] PRE_END = PRE_W'(PRE - 1);
         logic [PRE_W-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                pre_q <= '0;
            else if (access)           pre_q <= '0;
            else if (pre_q == PRE_END) pre_q <= '0;
            else                       pre_q <= pre_q + 1'b1;
         end
         assign ms_tick = (pre_q == PRE_END);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        ms_q <= '0;
      else if (access)                   ms_q <= '0;
      else if (ms_tick && ms_q != MS_END) ms_q <= ms_q + 1'b1;
   end

   assign expired    = (ms_q == MS_END);
   assign backlog_ok = !ext || (level >= BL_LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     state_q <= PORT_LIVE;
      else if (access)                state_q <= PORT_LIVE;
      else if (expired && backlog_ok) state_q <= PORT_IDLE;
   end

endmodule

// File: rtl/txrdy_idle_mon.sv
module txrdy_idle_mon
   import txr_pkg::*;
#(
   parameter int CLK_HZ  = 100_000_000,
   parameter int IDLE_MS = 2000,
   parameter int LVL_W   = 13,
   parameter int THR_MAX = 2048,
   parameter int BACKLOG = 4096
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic             cfg_enable,
   input  logic             cfg_active_low,
   input  logic             cfg_ext_timeout,
   input  logic [LVL_W-1:0] cfg_threshold,
   input  logic             host_access,
   input  logic [LVL_W-1:0] buf_level,
   output logic             tx_ready,
   output logic             port_idle
);

   generate
      if (CLK_HZ < 1000) begin : g_bad_clk
         $error("CLK_HZ must be at least 1000");
      end
      if (IDLE_MS < 1) begin : g_bad_ms
         $error("IDLE_MS must be at least 1");
      end
      if (THR_MAX >= (1 << LVL_W)) begin : g_bad_thr
         $error("THR_MAX does not fit in LVL_W");
      end
      if (BACKLOG >= (1 << LVL_W)) begin : g_bad_bl
         $error("BACKLOG does not fit in LVL_W");
      end
   endgenerate

   txr_flags_t       cfg_q;
   logic [LVL_W-1:0] thr_q;
   logic             armed;
   txr_port_e        port_st;

   txr_cfg_reg #(
      .LVL_W  (LVL_W),
      .THR_MAX(THR_MAX)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (cfg_wr),
      .en_in     (cfg_enable),
      .act_low_in(cfg_active_low),
      .ext_in    (cfg_ext_timeout),
      .thr_in    (cfg_threshold),
      .flags_q   (cfg_q),
      .thr_q     (thr_q)
   );

   txr_ready_ctrl #(
      .LVL_W(LVL_W)
   ) u_ready (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (cfg_q.en),
      .thr  (thr_q),
      .level(buf_level),
      .armed(armed)
   );

   txr_idle_timer #(
      .CLK_HZ (CLK_HZ),
      .IDLE_MS(IDLE_MS),
      .LVL_W  (LVL_W),
      .BACKLOG(BACKLOG)
   ) u_idle (
      .clk    (clk),
      .rst_n  (rst_n),
      .access (host_access),
      .ext    (cfg_q.ext),
      .level  (buf_level),
      .state_q(port_st)
   );

   assign tx_ready  = armed ^ cfg_q.act_low;
   assign port_idle = (port_st == PORT_IDLE);

endmodule

// File: rtl/txrdy_idle_mon_chk.sv
module txrdy_idle_mon_chk #(
   parameter int LVL_W   = 13,
   parameter int THR_MAX = 2048,
   parameter int BACKLOG = 4096
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_access,
   input logic [LVL_W-1:0] buf_level,
   input logic             armed,
   input logic             en_q,
   input logic             ext_q,
   input logic [LVL_W-1:0] thr_q,
   input logic             port_idle
);

   assert_arm_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> ($past(en_q) && $past(buf_level) != '0 && $past(buf_level) >= $past(thr_q)));

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && en_q && buf_level != '0) |=> armed);

   assert_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_level == '0) |=> !armed);

   assert_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> !armed);

   assert_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
      host_access |=> !port_idle);

   assert_backlog_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(port_idle) |-> ($past(!ext_q) || $past(buf_level) >= LVL_W'(BACKLOG)));

   assert_thr_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |-> (thr_q != '0 && thr_q <= LVL_W'(THR_MAX)));

endmodule

bind txrdy_idle_mon txrdy_idle_mon_chk #(
   .LVL_W  (LVL_W),
   .THR_MAX(THR_MAX),
   .BACKLOG(BACKLOG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_access(host_access),
   .buf_level  (buf_level),
   .armed      (armed),
   .en_q       (cfg_q.en),
   .ext_q      (cfg_q.ext),
   .thr_q      (thr_q),
   .port_idle  (port_idle)
);

// File: tb/txrdy_idle_mon_tb_top.sv
`timescale 1ns/1ps
module txrdy_idle_mon_tb_top;

   localparam int LVL_W   = 13;
   localparam int CLK_HZ  = 4000;
   localparam int IDLE_MS = 25;
   localparam int SILENT  = IDLE_MS * (CLK_HZ / 1000);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_wr = 1'b0;
   logic             cfg_enable = 1'b0;
   logic             cfg_active_low = 1'b0;
   logic             cfg_ext_timeout = 1'b0;
   logic [LVL_W-1:0] cfg_threshold = '0;
   logic             host_access = 1'b0;
   logic [LVL_W-1:0] buf_level = '0;
   logic             tx_ready;
   logic             port_idle;

   int    vectors = 0;
   int    errors  = 0;
   bit    done    = 1'b0;
   string phase   = "R1";

   // behavioural model state
   bit m_en, m_pol, m_ext, m_armed, m_idle;
   int m_thr, m_sil;

   always #5 clk = ~clk;

   txrdy_idle_mon #(
      .CLK_HZ (CLK_HZ),
      .IDLE_MS(IDLE_MS),
      .LVL_W  (LVL_W)
   ) dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_wr         (cfg_wr),
      .cfg_enable     (cfg_enable),
      .cfg_active_low (cfg_active_low),
      .cfg_ext_timeout(cfg_ext_timeout),
      .cfg_threshold  (cfg_threshold),
      .host_access    (host_access),
      .buf_level      (buf_level),
      .tx_ready       (tx_ready),
      .port_idle      (port_idle)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_pol = 0; m_ext = 0; m_armed = 0; m_idle = 0;
         m_thr = 0; m_sil = 0;
      end else begin
         int lv;
         bit nxt;
         lv  = int'(buf_level);
         nxt = m_en && lv != 0 && (m_armed || lv >= m_thr);
         if (host_access) begin
            m_idle = 0;
            m_sil  = 0;
         end else begin
            if (m_sil >= SILENT && (!m_ext || lv >= 4096)) m_idle = 1;
            if (m_sil < SILENT) m_sil++;
         end
         m_armed = nxt;
         if (cfg_wr) begin
            m_ext = cfg_ext_timeout;
            if (cfg_enable && (cfg_threshold == 0 || int'(cfg_threshold) > 2048)) begin
               m_en = 0; m_pol = 0; m_thr = 0;
            end else begin
               m_en = cfg_enable; m_pol = cfg_active_low; m_thr = int'(cfg_threshold);
            end
         end
      end
      #2;
      if (!done) begin
         vectors++;
         if (tx_ready !== (m_armed ^ m_pol) || port_idle !== m_idle) begin
            errors++;
            $display("FAIL %s model: tx_ready=%b port_idle=%b expected %b %b",
                     phase, tx_ready, port_idle, m_armed ^ m_pol, m_idle);
         end
      end
   end

   task automatic chk(input string tag, input logic got, input logic exp);
      vectors++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b", tag, got, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_cfg(input bit en, input bit pol, input bit ext, input int thr);
      @(negedge clk);
      cfg_enable = en; cfg_active_low = pol; cfg_ext_timeout = ext;
      cfg_threshold = LVL_W'(thr); cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic set_lvl(input int v);
      @(negedge clk);
      buf_level = LVL_W'(v);
      @(negedge clk);
   endtask

   task automatic poke_host();
      @(negedge clk);
      host_access = 1'b1;
      @(negedge clk);
      host_access = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      @(negedge clk);
      phase = "R1";
      chk("R1 tx_ready after reset", tx_ready, 1'b0);
      chk("R1 port_idle after reset", port_idle, 1'b0);
      set_lvl(50);
      chk("R1 disabled pin ignores data", tx_ready, 1'b0);
      set_lvl(0);

      // threshold arm, hold, drain
      poke_host();
      phase = "R3";
      set_cfg(1, 0, 0, 10);
      set_lvl(9);
      chk("R5 below threshold", tx_ready, 1'b0);
      set_lvl(10);
      chk("R3 arm at threshold", tx_ready, 1'b1);
      phase = "R4";
      set_lvl(3);
      chk("R4 hold below threshold", tx_ready, 1'b1);
      set_lvl(0);
      chk("R4 release on drain", tx_ready, 1'b0);
      phase = "R5";
      set_lvl(5);
      chk("R5 no re-arm below threshold", tx_ready, 1'b0);
      set_lvl(0);

      // polarity and max threshold
      poke_host();
      phase = "R2";
      set_cfg(1, 1, 0, 2048);
      chk("R2 inactive level is high when active-low", tx_ready, 1'b1);
      phase = "R10";
      set_lvl(2047);
      chk("R10 2047 below 2048 threshold", tx_ready, 1'b1);
      set_lvl(2048);
      chk("R10 threshold 2048 accepted and active-low asserted", tx_ready, 1'b0);
      set_lvl(0);
      chk("R2 back to inactive high", tx_ready, 1'b1);

      // rejected thresholds
      poke_host();
      phase = "R9";
      set_cfg(1, 1, 0, 2049);
      chk("R9 threshold 2049 clears polarity", tx_ready, 1'b0);
      set_lvl(3000);
      chk("R9 threshold 2049 leaves pin disabled", tx_ready, 1'b0);
      set_cfg(1, 0, 0, 0);
      set_lvl(100);
      chk("R9 threshold 0 leaves pin disabled", tx_ready, 1'b0);
      set_lvl(0);

      // silence timeout
      phase = "R6";
      poke_host();
      wait_n(SILENT - 10);
      chk("R6 not idle before interval", port_idle, 1'b0);
      wait_n(20);
      chk("R6 idle after interval", port_idle, 1'b1);
      phase = "R8";
      poke_host();
      chk("R8 access clears idle", port_idle, 1'b0);
      wait_n(SILENT - 10);
      chk("R8 interval restarted", port_idle, 1'b0);
      wait_n(20);
      chk("R8 idle again after restarted interval", port_idle, 1'b1);

      // extended mode loaded through a rejected write
      phase = "R7";
      set_cfg(1, 0, 1, 4000);
      poke_host();
      set_lvl(100);
      wait_n(SILENT + 30);
      chk("R7 R9 small backlog keeps port live", port_idle, 1'b0);
      set_lvl(4095);
      wait_n(2);
      chk("R7 backlog 4095 keeps port live", port_idle, 1'b0);
      set_lvl(4096);
      chk("R7 backlog 4096 declares idle", port_idle, 1'b1);
      poke_host();
      chk("R8 access clears extended idle", port_idle, 1'b0);

      wait_n(2);
      finish_run();
   end

endmodule